// File: doc/BRIEF.md
# Exception Entry Unit

This block applies the register updates a scalar RISC core makes at the moment it takes an exception. A request arrives with a cause code, the program counter of the faulting instruction, a flag that marks an instruction sitting in a branch delay slot, the current control bits of the status word, and the address that caused the fault. At the next rising clock edge the unit captures a consistent set of results:

- the return address;
- a copy of the status word exactly as it was before the exception;
- the new supervisor-mode status word;
- the fault-address register;
- the handler vector, with a valid pulse;
- one-cycle pulses that drop the load-linked reservation and cancel the power-management sleep enable.

Two points of order matter here. The saved status copy is taken before any bit is changed. The delay-slot marker is then written only into the new status word. For a fault in a delay slot, the return address is rewound by one instruction so that it points at the owning branch. Cause codes that are zero or outside the defined range are ignored.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted request, every register output is zero and vector_valid_o, lock_clr_o and sleep_clr_o are low.
- R2: On an accepted request, epc_o becomes pc_i. It becomes pc_i-4 when dslot_i is set and pc_i+4 when the cause is the system call (code 11). When both apply, the two adjustments cancel and epc_o is pc_i.
- R3: On an accepted request, esr_o becomes sr_i unchanged, including bit 5 (delay-slot marker) exactly as it came in.
- R4: On an accepted request, sr_o equals sr_i with the following changes: bit 0 (supervisor) is set; bits 1 (interrupt enable), 2 (tick timer enable), 3 (instruction MMU enable) and 4 (data MMU enable) are cleared. All other bits are kept.
- R5: On an accepted request, bit 5 of sr_o equals dslot_i.
- R6: On an accepted request with cause 2, 3, 4 or 5 (address-related faults), eear_o becomes fault_addr_i. For any other accepted cause, eear_o keeps its value.
- R7: One cycle after an accepted request, vector_valid_o pulses high for one cycle and vector_o equals the cause shifted left by 8. vector_o holds that value until the next accepted request.
- R8: One cycle after an accepted request, lock_clr_o and sleep_clr_o each pulse high for exactly one cycle.
- R9: A request with cause 0 or cause 14 or above changes no register output and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_req_i | input | 1 | Exception request, sampled at the rising edge |
| exc_cause_i | input | 4 | Cause code |
| pc_i | input | 32 | Program counter of the faulting instruction |
| dslot_i | input | 1 | Faulting instruction is in a branch delay slot |
| sr_i | input | 16 | Current status control bits |
| fault_addr_i | input | 32 | Faulting effective address |
| epc_o | output | 32 | Exception return address |
| esr_o | output | 16 | Saved status word |
| sr_o | output | 16 | New status word |
| eear_o | output | 32 | Fault-address register |
| vector_o | output | 32 | Handler address |
| vector_valid_o | output | 1 | Handler address is new this cycle |
| lock_clr_o | output | 1 | Drop load-linked reservation |
| sleep_clr_o | output | 1 | Cancel power-management sleep enable |

## Verification
Every result is registered once, so all outputs for a request sampled at one rising edge are due right after that edge. The pulses fall again one edge later. The bench applies each request half a period before an edge and reads the outputs at the following falling edge. At that same point it lowers the request, so each pulse can be checked for its single-cycle width at the next falling edge. The bench sweeps every cause code, both delay-slot values and several program counter, status and address patterns. A running model of the held registers lets it check that ignored causes and non-address causes leave the outputs untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int SR_W = 16;

  localparam int SR_SUPV  = 0;
  localparam int SR_IRQEN = 1;
  localparam int SR_TICK  = 2;
  localparam int SR_IMMU  = 3;
  localparam int SR_DMMU  = 4;
  localparam int SR_DSLOT = 5;

  localparam int CAUSE_BUSERR  = 2;
  localparam int CAUSE_DPAGE   = 3;
  localparam int CAUSE_IPAGE   = 4;
  localparam int CAUSE_ALIGN   = 5;
  localparam int CAUSE_SYSCALL = 11;

  typedef struct packed {
    logic take;
    logic addr_fault;
    logic syscall;
  } exc_decode_t;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W    = 4,
  parameter int NUM_CAUSES = 14
) (
  input  logic               req_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_decode_t        dec_o
);
  localparam int NUM_ADDR = 4;
  localparam int ADDR_CODES [NUM_ADDR] = '{CAUSE_BUSERR, CAUSE_DPAGE, CAUSE_IPAGE, CAUSE_ALIGN};

  logic [NUM_ADDR-1:0] addr_hit;
  logic                in_range;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_addr
    assign addr_hit[g] = (32'(cause_i) == 32'(ADDR_CODES[g]));
  end

  assign in_range = (cause_i != '0) && (32'(cause_i) < 32'(NUM_CAUSES));

  always_comb begin
    dec_o.take       = req_i && in_range;
    dec_o.addr_fault = |addr_hit;
    dec_o.syscall    = (32'(cause_i) == 32'(CAUSE_SYSCALL));
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            dslot_i,
  input  logic            syscall_i,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] rewound;

  always_comb begin
    rewound = dslot_i ? (pc_i - STEP) : pc_i;
    epc_o   = syscall_i ? (rewound + STEP) : rewound;
  end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
  import exc_entry_pkg::*;
(
  input  logic [SR_W-1:0] sr_i,
  input  logic            dslot_i,
  output logic [SR_W-1:0] sr_o
);
  localparam logic [SR_W-1:0] CLR_MASK =
      (SR_W'(1) << SR_IRQEN) | (SR_W'(1) << SR_TICK) |
      (SR_W'(1) << SR_IMMU)  | (SR_W'(1) << SR_DMMU) |
      (SR_W'(1) << SR_DSLOT);

  always_comb begin
    sr_o           = sr_i & ~CLR_MASK;
    sr_o[SR_SUPV]  = 1'b1;
    sr_o[SR_DSLOT] = dslot_i;
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int NUM_CAUSES = 14,
  parameter int VEC_SHIFT  = 8,
  parameter int INSN_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               dslot_i,
  input  logic [SR_W-1:0]    sr_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  output logic [XLEN-1:0]    epc_o,
  output logic [SR_W-1:0]    esr_o,
  output logic [SR_W-1:0]    sr_o,
  output logic [XLEN-1:0]    eear_o,
  output logic [XLEN-1:0]    vector_o,
  output logic               vector_valid_o,
  output logic               lock_clr_o,
  output logic               sleep_clr_o
);
  logic            rst_sync_n;
  exc_decode_t     dec;
  logic [XLEN-1:0] epc_calc;
  logic [SR_W-1:0] sr_calc;

  logic [XLEN-1:0] epc_d, epc_q, eear_d, eear_q, vec_d, vec_q;
  logic [SR_W-1:0] esr_d, esr_q, sr_d, sr_q;
  logic            pulse_d, pulse_q;

  exc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  exc_cause_decode #(.CAUSE_W(CAUSE_W), .NUM_CAUSES(NUM_CAUSES)) u_dec (
    .req_i  (exc_req_i),
    .cause_i(exc_cause_i),
    .dec_o  (dec)
  );

  exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .pc_i     (pc_i),
    .dslot_i  (dslot_i),
    .syscall_i(dec.syscall),
    .epc_o    (epc_calc)
  );

  exc_sr_update u_sr (
    .sr_i   (sr_i),
    .dslot_i(dslot_i),
    .sr_o   (sr_calc)
  );

  always_comb begin
    epc_d   = epc_q;
    esr_d   = esr_q;
    sr_d    = sr_q;
    eear_d  = eear_q;
    vec_d   = vec_q;
    pulse_d = 1'b0;
    if (dec.take) begin
      epc_d   = epc_calc;
      esr_d   = sr_i;
      sr_d    = sr_calc;
      vec_d   = XLEN'(exc_cause_i) << VEC_SHIFT;
      pulse_d = 1'b1;
      if (dec.addr_fault) eear_d = fault_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      epc_q   <= '0;
      esr_q   <= '0;
      sr_q    <= '0;
      eear_q  <= '0;
      vec_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      epc_q   <= epc_d;
      esr_q   <= esr_d;
      sr_q    <= sr_d;
      eear_q  <= eear_d;
      vec_q   <= vec_d;
      pulse_q <= pulse_d;
    end
  end

  assign epc_o          = epc_q;
  assign esr_o          = esr_q;
  assign sr_o           = sr_q;
  assign eear_o         = eear_q;
  assign vector_o       = vec_q;
  assign vector_valid_o = pulse_q;
  assign lock_clr_o     = pulse_q;
  assign sleep_clr_o    = pulse_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int NUM_CAUSES = 14,
  parameter int VEC_SHIFT  = 8,
  parameter int INSN_BYTES = 4
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               exc_req_i,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic [XLEN-1:0]    pc_i,
  input logic               dslot_i,
  input logic [SR_W-1:0]    sr_i,
  input logic [XLEN-1:0]    epc_o,
  input logic [SR_W-1:0]    esr_o,
  input logic [SR_W-1:0]    sr_o,
  input logic [XLEN-1:0]    eear_o,
  input logic [XLEN-1:0]    vector_o,
  input logic               vector_valid_o,
  input logic               lock_clr_o,
  input logic               sleep_clr_o
);
  logic            ok_cause, take, drop, sys;
  logic [XLEN-1:0] exp_epc;

  assign ok_cause = (exc_cause_i != '0) && (32'(exc_cause_i) < 32'(NUM_CAUSES));
  assign take     = exc_req_i && ok_cause;
  assign drop     = exc_req_i && !ok_cause;
  assign sys      = (32'(exc_cause_i) == 32'(CAUSE_SYSCALL));
  assign exp_epc  = pc_i + (sys ? XLEN'(INSN_BYTES) : '0) - (dslot_i ? XLEN'(INSN_BYTES) : '0);

  assert_epc_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> epc_o == $past(exp_epc));

  assert_esr_snapshot_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> esr_o == $past(sr_i));

  assert_sr_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> sr_o[SR_SUPV] && !sr_o[SR_IRQEN] && !sr_o[SR_TICK] && !sr_o[SR_IMMU] && !sr_o[SR_DMMU]);

  assert_dslot_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> sr_o[SR_DSLOT] == $past(dslot_i));

  assert_vector_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> vector_valid_o && vector_o == (XLEN'($past(exc_cause_i)) << VEC_SHIFT));

  assert_pulses_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    take |=> lock_clr_o && sleep_clr_o);

  assert_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    drop |=> !vector_valid_o && !lock_clr_o && $stable(epc_o) && $stable(esr_o)
             && $stable(sr_o) && $stable(eear_o));
endmodule

bind exc_entry_unit exc_entry_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .NUM_CAUSES(NUM_CAUSES),
  .VEC_SHIFT(VEC_SHIFT), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .exc_req_i(exc_req_i),
  .exc_cause_i(exc_cause_i), .pc_i(pc_i), .dslot_i(dslot_i), .sr_i(sr_i),
  .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o), .eear_o(eear_o),
  .vector_o(vector_o), .vector_valid_o(vector_valid_o),
  .lock_clr_o(lock_clr_o), .sleep_clr_o(sleep_clr_o)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        exc_req_i;
  logic [3:0]  exc_cause_i;
  logic [31:0] pc_i, fault_addr_i;
  logic        dslot_i;
  logic [15:0] sr_i;
  logic [31:0] epc_o, eear_o, vector_o;
  logic [15:0] esr_o, sr_o;
  logic        vector_valid_o, lock_clr_o, sleep_clr_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_epc, m_eear, m_vec;
  logic [15:0] m_esr, m_sr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exc_entry_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
    .pc_i(pc_i), .dslot_i(dslot_i), .sr_i(sr_i), .fault_addr_i(fault_addr_i),
    .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o), .eear_o(eear_o), .vector_o(vector_o),
    .vector_valid_o(vector_valid_o), .lock_clr_o(lock_clr_o), .sleep_clr_o(sleep_clr_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(epc_o == m_epc, {req, " epc"}, epc_o, m_epc);
    chk(esr_o == m_esr, {req, " esr"}, 32'(esr_o), 32'(m_esr));
    chk(sr_o == m_sr, {req, " sr"}, 32'(sr_o), 32'(m_sr));
    chk(eear_o == m_eear, {req, " eear"}, eear_o, m_eear);
    chk(vector_o == m_vec, {req, " vector"}, vector_o, m_vec);
  endtask

  task automatic apply(input int cause, input logic ds, input logic [31:0] pc,
                       input logic [15:0] sr, input logic [31:0] fa);
    bit valid, addrf, sys;
    @(negedge clk_i);
    exc_req_i = 1'b1; exc_cause_i = 4'(cause); dslot_i = ds;
    pc_i = pc; sr_i = sr; fault_addr_i = fa;
    valid = (cause != 0) && (cause < 14);
    addrf = (cause >= 2) && (cause <= 5);
    sys   = (cause == 11);
    if (valid) begin
      m_epc = pc + (sys ? 32'd4 : 32'd0) - (ds ? 32'd4 : 32'd0);
      m_esr = sr;
      m_sr  = (sr & ~16'h003E) | 16'h0001 | (ds ? 16'h0020 : 16'h0000);
      if (addrf) m_eear = fa;
      m_vec = 32'(cause) << 8;
    end
    @(negedge clk_i);
    exc_req_i = 1'b0;
    if (valid) begin
      chk_state($sformatf("R2/R3/R4/R5/R6/R7 cause=%0d ds=%0d", cause, ds));
      chk(m_sr[5] == sr_o[5], "R5 dsx", 32'(sr_o[5]), 32'(ds));
      chk(vector_valid_o, "R7 vector_valid", 32'(vector_valid_o), 1);
      chk(lock_clr_o && sleep_clr_o, "R8 pulses", {30'd0, lock_clr_o, sleep_clr_o}, 32'd3);
    end else begin
      chk_state($sformatf("R9 ignored cause=%0d", cause));
      chk(!vector_valid_o && !lock_clr_o && !sleep_clr_o, "R9 no pulse",
          {29'd0, vector_valid_o, lock_clr_o, sleep_clr_o}, 32'd0);
    end
    @(negedge clk_i);
    chk(!vector_valid_o && !lock_clr_o && !sleep_clr_o, "R8 single-cycle pulse",
        {29'd0, vector_valid_o, lock_clr_o, sleep_clr_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; exc_req_i = 1'b0; exc_cause_i = '0; dslot_i = 1'b0;
    pc_i = '0; sr_i = '0; fault_addr_i = '0;
    m_epc = '0; m_esr = '0; m_sr = '0; m_eear = '0; m_vec = '0;
    repeat (3) @(negedge clk_i);
    chk_state("R1 in reset");
    chk(!vector_valid_o && !lock_clr_o && !sleep_clr_o, "R1 pulses in reset",
        {29'd0, vector_valid_o, lock_clr_o, sleep_clr_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_state("R1 after reset");

    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 16; c++) begin
        for (int d = 0; d < 2; d++) begin
          apply(c, d[0], 32'h0000_1000 + 32'(p * 32'h0123_4560) + 32'(c * 16),
                16'(16'hA5C3 ^ (p * 16'h3F17) ^ (c << 4)) | (d[0] ? 16'h0000 : 16'h0020),
                32'hDEAD_0000 + 32'(p * 256 + c * 4 + d));
        end
      end
    end
    apply(11, 1'b1, 32'h0000_0004, 16'hFFFF, 32'h1);
    apply(2, 1'b1, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFC);
    apply(0, 1'b0, 32'h1234_5678, 16'h1234, 32'h5555_5555);
    apply(15, 1'b1, 32'h8765_4321, 16'h4321, 32'hAAAA_AAAA);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule